// File: doc/BRIEF.md
# Programmable periodic interrupt timer

This block produces a regular one-clock interrupt pulse that paces the accumulation cycle of a multi-channel correlator. A down counter runs at a reduced rate set by a clock-enable prescaler. The prescaler divides the system clock by 7 when the front-end runs with real samples and by 6 when it runs with complex samples. When the counter has counted down through zero it fires the pulse, reloads from a preset register and starts again. With a preset of P the pulse repeats every (P+1) counter ticks.

The preset can change in two ways. Firmware can write a value directly. The block also loads one of four built-in constants whenever either of its two mode inputs changes. These inputs are the sample-format bit and the short/long period bit. The most recent update wins. A new preset waits for the next reload, so the period that is running finishes at its old length.

The write strobe is a plain single-cycle control input with no handshake. Every strobed write is accepted, and the block never stalls the writer.

Top module: `periodic_irq_timer`

## Requirements
- R1: The counter steps P, P-1, ..., 1, 0 on counter ticks and then reloads the preset, so consecutive interrupts are (P+1) ticks apart.
- R2: A counter tick occurs once every 7 system clocks while `mode_cplx` is 0 (real samples) and once every 6 system clocks while it is 1 (complex samples).
- R3: `irq` is high for exactly one system clock, the clock in which a tick occurs while the counter holds 0.
- R4: While `rst_n` is low, `irq` is 0. Reset clears the prescaler and loads both the preset and the counter with the constant for both mode bits low.
- R5: A change in either direction on `mode_cplx` or `period_long`, found by comparing each bit with its value on the previous clock, loads the constant selected by the new bit values. The selector is {mode_cplx, period_long}: 00 loads 0x0B45, 01 loads 0x1313, 10 loads 0x0B81 and 11 loads 0x1379. Each constant is a parameter.
- R6: When `wr_en` is high, bits 12:0 of `wr_data` go into the preset register and bits 15:13 are ignored.
- R7: If a write and a mode-bit change occur in the same clock, the written value is kept.
- R8: A preset update does not disturb the count in progress. It takes effect at the next reload from zero.
- R9: The two update paths may be used in either order, and the later update sets the period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous master reset, active low |
| mode_cplx | input | 1 | Sample format: 0 = real (divide by 7), 1 = complex (divide by 6) |
| period_long | input | 1 | Selects the short (0) or long (1) built-in period |
| wr_en | input | 1 | Write strobe for the preset register |
| wr_data | input | 16 | Write data; bits 12:0 are the preset |
| irq | output | 1 | Periodic one-clock interrupt pulse |

## Verification
The bench keeps the 13-bit counter and the 7/6 prescaler at their default values. It overrides the four built-in presets with 20, 33, 24 and 41. With these values a full interrupt period lasts only a few hundred clocks, so every table entry, both divisors and every ordering of writes and mode changes fit in one short run. The same mechanics also let the bench check the interval between pulses exactly, including a mode change in the middle of a period and a write that lands in the same clock as a mode-bit edge.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;

  typedef enum logic [1:0] {
    SEL_REAL_SHORT = 2'b00,
    SEL_REAL_LONG  = 2'b01,
    SEL_CPLX_SHORT = 2'b10,
    SEL_CPLX_LONG  = 2'b11
  } preset_sel_e;

  function automatic preset_sel_e mode_to_sel(input logic cplx, input logic long_p);
    return preset_sel_e'({cplx, long_p});
  endfunction

endpackage

// File: rtl/ptimer_prescaler.sv
module ptimer_prescaler #(
  parameter int unsigned REAL_DIV = 7,
  parameter int unsigned CPLX_DIV = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cplx,
  output logic tick
);
  localparam int unsigned MAX_DIV = (REAL_DIV > CPLX_DIV) ? REAL_DIV : CPLX_DIV;
  localparam int unsigned PW      = (MAX_DIV > 2) ? $clog2(MAX_DIV) : 1;
  localparam logic [PW-1:0] REAL_LIM = PW'(REAL_DIV - 1);
  localparam logic [PW-1:0] CPLX_LIM = PW'(CPLX_DIV - 1);
  localparam logic [PW-1:0] MAX_LIM  = PW'(MAX_DIV - 1);

  logic [PW-1:0] phase;
  logic [PW-1:0] limit;

  // A shrinking divisor may leave phase above the new limit: >= ends the cycle at once.
  always_comb begin
    limit = cplx ? CPLX_LIM : REAL_LIM;
    tick  = (phase >= limit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    phase <= '0;
    else if (tick) phase <= '0;
    else           phase <= phase + PW'(1);
  end

  assert_phase_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= MAX_LIM);
  assert_tick_spaced_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
  assert_phase_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> phase == '0);

endmodule

// File: rtl/ptimer_preset.sv
module ptimer_preset
  import ptimer_pkg::*;
#(
  parameter int unsigned CNT_W          = 13,
  parameter int unsigned DATA_W         = 16,
  parameter int unsigned P_REAL_SHORT   = 'h0B45,
  parameter int unsigned P_REAL_LONG    = 'h1313,
  parameter int unsigned P_CPLX_SHORT   = 'h0B81,
  parameter int unsigned P_CPLX_LONG    = 'h1379
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cplx,
  input  logic              long_p,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CNT_W-1:0]  preset
);
  logic             cplx_q, long_q;
  logic             mode_edge;
  logic [CNT_W-1:0] table_val;
  logic             unused_hi;

  assign unused_hi = ^wr_data[DATA_W-1:CNT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cplx_q <= 1'b0;
      long_q <= 1'b0;
    end else begin
      cplx_q <= cplx;
      long_q <= long_p;
    end
  end

  assign mode_edge = (cplx ^ cplx_q) | (long_p ^ long_q);

  always_comb begin
    unique case (mode_to_sel(cplx, long_p))
      SEL_REAL_SHORT: table_val = CNT_W'(P_REAL_SHORT);
      SEL_REAL_LONG:  table_val = CNT_W'(P_REAL_LONG);
      SEL_CPLX_SHORT: table_val = CNT_W'(P_CPLX_SHORT);
      SEL_CPLX_LONG:  table_val = CNT_W'(P_CPLX_LONG);
      default:        table_val = CNT_W'(P_REAL_SHORT);
    endcase
  end

  // Direct write outranks a simultaneous mode edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         preset <= CNT_W'(P_REAL_SHORT);
    else if (wr_en)     preset <= wr_data[CNT_W-1:0];
    else if (mode_edge) preset <= table_val;
  end

  assert_write_low_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> preset == $past(wr_data[CNT_W-1:0]));
  assert_edge_loads_table_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && mode_edge) |=> preset == $past(table_val));
  assert_preset_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !mode_edge) |=> $stable(preset));

endmodule

// File: rtl/ptimer_counter.sv
module ptimer_counter #(
  parameter int unsigned CNT_W     = 13,
  parameter int unsigned RESET_VAL = 'h0B45
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] preset,
  output logic             irq
);
  logic [CNT_W-1:0] count;
  logic             at_zero;

  assign at_zero = (count == '0);
  assign irq     = tick & at_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= CNT_W'(RESET_VAL);
    else if (irq)     count <= preset;
    else if (tick)    count <= count - CNT_W'(1);
  end

  assert_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count == '0) |=> count == $past(preset));
  assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count != '0) |=> count == $past(count) - CNT_W'(1));
  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));
  assert_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

endmodule

// File: rtl/periodic_irq_timer.sv
module periodic_irq_timer #(
  parameter int unsigned CNT_W        = 13,
  parameter int unsigned DATA_W       = 16,
  parameter int unsigned REAL_DIV     = 7,
  parameter int unsigned CPLX_DIV     = 6,
  parameter int unsigned P_REAL_SHORT = 'h0B45,
  parameter int unsigned P_REAL_LONG  = 'h1313,
  parameter int unsigned P_CPLX_SHORT = 'h0B81,
  parameter int unsigned P_CPLX_LONG  = 'h1379
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_cplx,
  input  logic              period_long,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              irq
);
  logic             tick;
  logic [CNT_W-1:0] preset;

  ptimer_prescaler #(
    .REAL_DIV (REAL_DIV),
    .CPLX_DIV (CPLX_DIV)
  ) u_prescaler (
    .clk   (clk),
    .rst_n (rst_n),
    .cplx  (mode_cplx),
    .tick  (tick)
  );

  ptimer_preset #(
    .CNT_W        (CNT_W),
    .DATA_W       (DATA_W),
    .P_REAL_SHORT (P_REAL_SHORT),
    .P_REAL_LONG  (P_REAL_LONG),
    .P_CPLX_SHORT (P_CPLX_SHORT),
    .P_CPLX_LONG  (P_CPLX_LONG)
  ) u_preset (
    .clk     (clk),
    .rst_n   (rst_n),
    .cplx    (mode_cplx),
    .long_p  (period_long),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .preset  (preset)
  );

  ptimer_counter #(
    .CNT_W     (CNT_W),
    .RESET_VAL (P_REAL_SHORT)
  ) u_counter (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .preset (preset),
    .irq    (irq)
  );

  assert_reset_quiet_R4: assert property (@(posedge clk)
    !rst_n |-> !irq);

endmodule

// File: tb/test_periodic_irq_timer.sv
module test_periodic_irq_timer;
  localparam int RS = 20, RL = 33, CS = 24, CL = 41;
  localparam int RDIV = 7, CDIV = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_cplx = 1'b0;
  logic        period_long = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  string cur_req = "R4";

  // behavioural reference state
  int m_phase = 0, m_cnt = RS, m_preset = RS;
  bit m_cq = 0, m_lq = 0;

  periodic_irq_timer #(
    .P_REAL_SHORT (RS), .P_REAL_LONG (RL),
    .P_CPLX_SHORT (CS), .P_CPLX_LONG (CL)
  ) i_periodic_irq_timer (
    .clk (clk), .rst_n (rst_n), .mode_cplx (mode_cplx),
    .period_long (period_long), .wr_en (wr_en), .wr_data (wr_data), .irq (irq)
  );

  always #2 clk = ~clk;

  function automatic int table_of(bit c, bit l);
    if (!c) return l ? RL : RS;
    return l ? CL : CS;
  endfunction

  function automatic bit model_tick();
    return m_phase >= ((mode_cplx ? CDIV : RDIV) - 1);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_phase = 0; m_cnt = RS; m_preset = RS; m_cq = 0; m_lq = 0;
    end else begin
      bit t;
      bit edge_seen;
      t = model_tick();
      edge_seen = (mode_cplx != m_cq) || (period_long != m_lq);
      if (t) begin
        m_phase = 0;
        m_cnt = (m_cnt == 0) ? m_preset : m_cnt - 1;
      end else m_phase++;
      if (wr_en) m_preset = wr_data & 16'h1FFF;
      else if (edge_seen) m_preset = table_of(mode_cplx, period_long);
      m_cq = mode_cplx; m_lq = period_long;
    end
  end

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      bit e;
      e = model_tick() && (m_cnt == 0);
      check(irq == e, cur_req, int'(irq), int'(e));
    end else begin
      check(irq == 1'b0, "R4", int'(irq), 0);
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wait_irq(output int at);
    do @(negedge clk); while (!irq);
    at = cyc;
  endtask

  task automatic measure(input int exp, input string req);
    int a, b;
    wait_irq(a);
    wait_irq(b);
    check(b - a == exp, req, b - a, exp);
  endtask

  task automatic do_write(input logic [15:0] d);
    step(); wr_en = 1'b1; wr_data = d;
    step(); wr_en = 1'b0;
  endtask

  initial begin : watchdog
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stimulus
    int a, b;
    repeat (5) step();
    rst_n = 1'b1;
    // R4: reset preset governs the first period
    cur_req = "R4";
    measure((RS + 1) * RDIV, "R4");
    // R1/R2: steady real-mode period
    cur_req = "R1";
    measure((RS + 1) * RDIV, "R1");
    // R8: toggle period_long mid-period; running period keeps old length
    cur_req = "R8";
    wait_irq(a);
    repeat (30) step();
    period_long = 1'b1;
    wait_irq(b);
    check(b - a == (RS + 1) * RDIV, "R8", b - a, (RS + 1) * RDIV);
    // R5: long real constant now in force
    cur_req = "R5";
    measure((RL + 1) * RDIV, "R5");
    // R2: complex mode divides by 6, table gives CL
    cur_req = "R2";
    step(); mode_cplx = 1'b1;
    measure((CL + 1) * CDIV, "R2");
    // R3: pulse lasts one clock
    cur_req = "R3";
    wait_irq(a);
    @(negedge clk);
    check(irq == 1'b0, "R3", int'(irq), 0);
    // R6: high bits ignored
    cur_req = "R6";
    do_write(16'hE00F);
    measure((15 + 1) * CDIV, "R6");
    // R7: write and edge in the same clock
    cur_req = "R7";
    step(); wr_en = 1'b1; wr_data = 16'd10; period_long = 1'b0;
    step(); wr_en = 1'b0;
    measure((10 + 1) * CDIV, "R7");
    // R9: edge then write -> write wins
    cur_req = "R9";
    step(); mode_cplx = 1'b0;
    repeat (3) step();
    do_write(16'd8);
    measure((8 + 1) * RDIV, "R9");
    // R9: write then edge -> table wins
    do_write(16'd30);
    repeat (3) step();
    period_long = 1'b1;
    measure((RL + 1) * RDIV, "R9");
    // R5: back to complex short
    cur_req = "R5";
    step(); mode_cplx = 1'b1; period_long = 1'b0;
    measure((CS + 1) * CDIV, "R5");
    repeat (3) step();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule